// File: doc/BRIEF.md
# Flash Read Accelerator

This block stands between a processor read port and a slow on-chip flash array. It keeps a small set of holding latches, each holding one flash word and its address, so that a word that was read before can be returned in the cycle it is requested. A miss costs a full flash access. Every real flash access takes a programmed number of clock cycles, from 1 to 7.

Two settings steer the block. A 2-bit mode selects how the latches are used: off, partial (sequential instruction fetches only) or full (every read). A 3-bit access-time value sets the length of a flash access. Software may rewrite either setting at any time. Writing a mode that differs from the current one empties every latch, and this keeps the latches consistent with flash across mode changes.

The processor raises `rd_req` and holds the request (address, fetch type and sequential flag) steady until `rd_ready` is high. The read completes in the cycle `rd_ready` is high.

Top module: `flash_accel`

## Requirements
- R1: After reset the mode readback is 0 (off), the access-time readback is 7, and neither `rd_ready` nor `fl_req` is high while no read is requested.
- R2: In mode 0 and in mode 3 (reserved, readback still 3) no read is served from a latch: every read starts a flash access, and no latch is loaded.
- R3: A read that goes to flash completes with `rd_ready` high in its T-th cycle, counting the request cycle as the first. T is the effective access time. `rd_data` equals the flash word at `rd_addr`.
- R4: An access-time value of 0 gives T = 7.
- R5: With access-time value 1, every read completes in its request cycle with the correct word, whatever the mode.
- R6: In mode 2 (full), any read (fetch or data) of an address held in a valid latch completes in its request cycle with the held word and starts no flash access.
- R7: In mode 1 (partial), only reads with `rd_ifetch`=1 and `rd_seq`=1 may be served from a latch. Data reads and non-sequential fetches always go to flash.
- R8: A mode write with a value different from the current mode invalidates all latches, even when it lands while an access is in flight. A write of the same value leaves the latches intact.
- R9: `fl_req` is high exactly in the cycles of a flash access. `fl_addr` equals `rd_addr`, and `fl_req` is never high without `rd_req`.
- R10: Latches are direct-mapped by the low log2(NLAT) address bits. In mode 1 or 2, a completed flash access loads its word into the latch for its index, and this replaces the previous occupant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_we | input | 1 | Write strobe for the mode setting |
| cfg_tim_we | input | 1 | Write strobe for the access-time setting |
| cfg_wdata | input | 3 | Write data (mode uses bits 1:0) |
| cfg_mode_q | output | 2 | Current mode readback |
| cfg_tim_q | output | 3 | Current access-time readback |
| rd_req | input | 1 | Read request, held until rd_ready |
| rd_addr | input | AW | Word address of the read |
| rd_ifetch | input | 1 | 1 = instruction fetch, 0 = data read |
| rd_seq | input | 1 | 1 = sequential to the previous fetch |
| rd_ready | output | 1 | Read completes this cycle |
| rd_data | output | DW | Read data, valid with rd_ready |
| fl_req | output | 1 | Flash access in progress |
| fl_addr | output | AW | Flash word address |
| fl_rdata | input | DW | Flash array data for fl_addr |

## Verification
The assertions check on every cycle that a flash access lasts exactly the effective access time, that off and reserved modes never bypass flash, that partial mode bypasses flash only for sequential fetches, and that a single-cycle setting always completes at once. Whether a latch actually holds a word, and so whether a read should hit, depends on history: fills, index conflicts, flushes on differing mode writes and the absence of a flush on same-value writes. Only the bench's reference model, which tracks that history across scripted scenarios including a mode change in the middle of an access, can show it.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PART = 2'd1,
    MODE_FULL = 2'd2,
    MODE_RSVD = 2'd3
  } fa_mode_e;

  localparam logic [2:0] TIM_RESET = 3'd7;

  // zero is clamped to the slowest legal access
  function automatic logic [2:0] fa_eff_tim(input logic [2:0] t);
    return (t == 3'd0) ? 3'd7 : t;
  endfunction
endpackage

// File: rtl/fa_regs.sv
module fa_regs
  import fa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic       tim_we,
  input  logic [2:0] wdata,
  output fa_mode_e   mode_q,
  output logic [2:0] tim_q,
  output logic       flush
);
  fa_mode_e   mode_d;
  logic [2:0] tim_d;

  always_comb begin
    mode_d = mode_q;
    tim_d  = tim_q;
    flush  = 1'b0;
    if (mode_we) begin
      mode_d = fa_mode_e'(wdata[1:0]);
      flush  = (wdata[1:0] != mode_q);
    end
    if (tim_we) tim_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      tim_q  <= TIM_RESET;
    end else begin
      mode_q <= mode_d;
      tim_q  <= tim_d;
    end
  end
endmodule

// File: rtl/fa_timer.sv
module fa_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [2:0] eff_tim,
  output logic       done,
  output logic       busy
);
  logic [2:0] cnt_q, cnt_d;
  logic [3:0] elapsed;

  assign elapsed = {1'b0, cnt_q} + 4'd1;
  assign done    = active && (elapsed == {1'b0, eff_tim});
  assign busy    = (cnt_q != 3'd0);

  always_comb begin
    cnt_d = 3'd0;
    if (active && !done) cnt_d = elapsed[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 3'd0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fa_hold.sv
module fa_hold #(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int NLAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  input  logic          flush,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int IDXW = (NLAT > 1) ? $clog2(NLAT) : 1;

  logic [NLAT-1:0] vld_q;
  logic [AW-1:0]   tag_q [NLAT];
  logic [DW-1:0]   dat_q [NLAT];
  logic [IDXW-1:0] idx;

  assign idx      = lk_addr[IDXW-1:0];
  assign hit      = vld_q[idx] && (tag_q[idx] == lk_addr);
  assign hit_data = dat_q[idx];

  for (genvar e = 0; e < NLAT; e++) begin : g_ent
    logic sel, vld_d, load_en;
    assign sel     = (idx == IDXW'(e));
    assign load_en = fill && sel;

    always_comb begin
      vld_d = vld_q[e];
      if (flush)        vld_d = 1'b0;
      else if (load_en) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[e] <= 1'b0;
      else        vld_q[e] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (load_en) begin
        tag_q[e] <= lk_addr;
        dat_q[e] <= fill_data;
      end
    end
  end
endmodule

// File: rtl/flash_accel.sv
module flash_accel
  import fa_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int NLAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode_we,
  input  logic          cfg_tim_we,
  input  logic [2:0]    cfg_wdata,
  output logic [1:0]    cfg_mode_q,
  output logic [2:0]    cfg_tim_q,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_ifetch,
  input  logic          rd_seq,
  output logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          fl_req,
  output logic [AW-1:0] fl_addr,
  input  logic [DW-1:0] fl_rdata
);
  logic       rst_meta, rst_sync;
  fa_mode_e   mode;
  logic [2:0] tim, eff_tim;
  logic       flush, lat_hit, use_ok, serve_hit, acc_active, acc_done, busy;
  logic       mode_on, fill;
  logic [DW-1:0] lat_data;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  fa_regs u_regs (
    .clk(clk), .rst_n(rst_sync), .mode_we(cfg_mode_we), .tim_we(cfg_tim_we),
    .wdata(cfg_wdata), .mode_q(mode), .tim_q(tim), .flush(flush)
  );

  assign eff_tim = fa_eff_tim(tim);

  always_comb begin
    unique case (mode)
      MODE_FULL: use_ok = 1'b1;
      MODE_PART: use_ok = rd_ifetch && rd_seq;
      default:   use_ok = 1'b0;
    endcase
  end

  assign mode_on    = (mode == MODE_PART) || (mode == MODE_FULL);
  assign serve_hit  = rd_req && !busy && use_ok && lat_hit;
  assign acc_active = rd_req && !serve_hit;
  assign fill       = acc_active && acc_done && mode_on && !flush;

  fa_timer u_timer (
    .clk(clk), .rst_n(rst_sync), .active(acc_active), .eff_tim(eff_tim),
    .done(acc_done), .busy(busy)
  );

  fa_hold #(.AW(AW), .DW(DW), .NLAT(NLAT)) u_hold (
    .clk(clk), .rst_n(rst_sync), .lk_addr(rd_addr), .fill(fill),
    .fill_data(fl_rdata), .flush(flush), .hit(lat_hit), .hit_data(lat_data)
  );

  assign rd_ready   = serve_hit || acc_done;
  assign rd_data    = serve_hit ? lat_data : fl_rdata;
  assign fl_req     = acc_active;
  assign fl_addr    = rd_addr;
  assign cfg_mode_q = mode;
  assign cfg_tim_q  = tim;
endmodule

// File: rtl/flash_accel_chk.sv
module flash_accel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode_q,
  input logic [2:0] cfg_tim_q,
  input logic       rd_req,
  input logic       rd_ifetch,
  input logic       rd_seq,
  input logic       rd_ready,
  input logic       fl_req
);
  logic [2:0] acc_cnt;
  logic [3:0] want;

  assign want = (cfg_tim_q == 3'd0) ? 4'd7 : {1'b0, cfg_tim_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  acc_cnt <= 3'd0;
    else if (rd_ready)           acc_cnt <= 3'd0;
    else if (fl_req)             acc_cnt <= acc_cnt + 3'd1;
  end

  // R3
  acc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && rd_ready) |-> (({1'b0, acc_cnt} + 4'd1) == want));

  // R9
  no_orphan_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> rd_req);

  // R9
  no_idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> rd_req);

  // R2
  off_goes_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (cfg_mode_q == 2'd0 || cfg_mode_q == 2'd3)) |-> fl_req);

  // R7
  partial_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cfg_mode_q == 2'd1 && !(rd_ifetch && rd_seq)) |-> fl_req);

  // R5
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cfg_tim_q == 3'd1) |-> rd_ready);
endmodule

bind flash_accel flash_accel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode_q(cfg_mode_q), .cfg_tim_q(cfg_tim_q),
  .rd_req(rd_req), .rd_ifetch(rd_ifetch), .rd_seq(rd_seq),
  .rd_ready(rd_ready), .fl_req(fl_req)
);

// File: tb/flash_accel_bench.sv
module flash_accel_bench;
  localparam int AW = 12, DW = 32, NLAT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_mode_we = 1'b0, cfg_tim_we = 1'b0;
  logic [2:0] cfg_wdata = 3'd0;
  logic [1:0] cfg_mode_q;
  logic [2:0] cfg_tim_q;
  logic rd_req = 1'b0, rd_ifetch = 1'b0, rd_seq = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_ready, fl_req;
  logic [DW-1:0] rd_data, fl_rdata;
  logic [AW-1:0] fl_addr;

  int total = 0, bad = 0, cyc = 0;
  int mmode = 0, mtim = 7;
  bit mvld [NLAT];
  int mtag [NLAT];

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] fword(input logic [AW-1:0] a);
    return ({20'd0, a} * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  assign fl_rdata = fword(fl_addr);

  flash_accel #(.AW(AW), .DW(DW), .NLAT(NLAT)) u_flash_accel (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected below 100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int t);
    return (t == 0) ? 7 : t;
  endfunction

  task automatic wr_mode(input int v);
    @(posedge clk); #1;
    cfg_mode_we = 1'b1; cfg_wdata = 3'(v);
    @(posedge clk); #1;
    cfg_mode_we = 1'b0;
    if (v != mmode) foreach (mvld[i]) mvld[i] = 0;
    mmode = v;
  endtask

  task automatic wr_tim(input int v);
    @(posedge clk); #1;
    cfg_tim_we = 1'b1; cfg_wdata = 3'(v);
    @(posedge clk); #1;
    cfg_tim_we = 1'b0;
    mtim = v;
  endtask

  // one read; optional mode write issued in cycle chg_at of the access
  task automatic rd(input int a, input bit ifc, input bit sq, input string req,
                    input int chg_at = 0, input int chg_val = 0);
    int idx, exp_lat, got_lat;
    bit exp_hit, lat_ok;
    logic [DW-1:0] got;
    idx = a % NLAT;
    exp_hit = mvld[idx] && mtag[idx] == a &&
              (mmode == 2 || (mmode == 1 && ifc && sq));
    exp_lat = exp_hit ? 1 : eff(mtim);
    @(posedge clk); #1;
    rd_req = 1'b1; rd_addr = AW'(a); rd_ifetch = ifc; rd_seq = sq;
    got_lat = 0; lat_ok = 1; got = '0;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (c == 1) chk(fl_req == !exp_hit && fl_addr == AW'(a),
                      {req, " R9 flash request"}, int'(fl_req), int'(!exp_hit));
      if (rd_ready != (c == exp_lat)) lat_ok = 0;
      if (rd_ready) begin got_lat = c; got = rd_data; break; end
      if (c == chg_at) begin
        cfg_mode_we = 1'b1; cfg_wdata = 3'(chg_val);
        if (chg_val != mmode) foreach (mvld[i]) mvld[i] = 0;
        mmode = chg_val;
      end
      @(posedge clk); #1;
      cfg_mode_we = 1'b0;
    end
    @(posedge clk); #1;
    rd_req = 1'b0;
    chk(lat_ok && got_lat == exp_lat, {req, " latency"}, got_lat, exp_lat);
    chk(got == fword(AW'(a)), {req, " data"}, int'(got), int'(fword(AW'(a))));
    if (!exp_hit && (mmode == 1 || mmode == 2)) begin
      mvld[idx] = 1; mtag[idx] = a;
    end
  endtask

  initial begin
    foreach (mvld[i]) mvld[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(cfg_mode_q == 2'd0, "R1 mode reset", int'(cfg_mode_q), 0);
    chk(cfg_tim_q == 3'd7, "R1 timing reset", int'(cfg_tim_q), 7);
    chk(!rd_ready && !fl_req, "R1 idle outputs", int'(rd_ready | fl_req), 0);

    // R2: off mode, repeated fetches all go to flash at T=7 (R3)
    rd(16, 1, 1, "R2 off first");
    rd(16, 1, 1, "R2 off repeat");

    // R6: full mode
    wr_tim(3);
    wr_mode(2);
    rd(5, 0, 0, "R3 full miss");
    rd(5, 0, 0, "R6 data hit");
    rd(5, 1, 0, "R6 fetch hit");
    // R10: same index, different address evicts
    rd(13, 0, 0, "R10 conflict miss");
    rd(5, 0, 0, "R10 evicted");
    rd(13, 0, 0, "R10 resident");

    // R4: timing 0 behaves as 7
    wr_tim(0);
    chk(cfg_tim_q == 3'd0, "R4 readback", int'(cfg_tim_q), 0);
    rd(40, 0, 0, "R4 clamp miss");
    rd(40, 0, 0, "R4 hit");

    // R8 + R7: partial mode flushes
    wr_mode(1);
    rd(40, 1, 1, "R8 flushed");
    rd(40, 1, 1, "R7 seq fetch hit");
    rd(40, 0, 0, "R7 data read");
    rd(40, 1, 0, "R7 nonseq fetch");
    wr_mode(1);
    rd(40, 1, 1, "R8 same value keeps");

    // R2 reserved mode
    wr_mode(3);
    chk(cfg_mode_q == 2'd3, "R2 reserved readback", int'(cfg_mode_q), 3);
    rd(40, 1, 1, "R2 reserved");
    rd(40, 1, 1, "R2 reserved no fill");
    wr_mode(2);
    rd(40, 0, 0, "R8 after reserved");

    // R5 single-cycle access
    wr_tim(1);
    rd(70, 0, 0, "R5 miss");
    rd(70, 1, 1, "R5 hit");
    wr_mode(0);
    rd(70, 0, 0, "R5 off");

    // R8 mode change mid-access
    wr_tim(5);
    wr_mode(2);
    rd(22, 0, 0, "R8 prefill");
    rd(99, 0, 0, "R8 midstream", 2, 1);
    rd(99, 1, 1, "R8 midstream fill");
    rd(22, 1, 1, "R8 midstream flushed");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule